// File: doc/BRIEF.md
# Masked Vector Merge Unit

This unit builds a destination vector one element at a time by choosing, for each element index, between two candidate values. The per-element choice comes from a 64-bit mask. A polarity bit is given with each operation. When the mask bit for an element equals the polarity bit, the element takes the first operand. Otherwise it takes the element of the second source vector at the same index.

The first operand has two modes. It can be the matching element of a source vector. It can also be one 64-bit scalar that is broadcast to every element that picks it. The register file lives outside the block. The unit drives an element index onto two asynchronous read ports. It takes the returned data in the same cycle and issues one write per cycle, with its index, toward the destination.

An operation starts with a one-cycle start pulse while the unit is idle. The length, mask, polarity, mode and scalar are captured at that moment. A done pulse follows the last write.

Top module: `vmerge_unit`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are all low.
- R2: A start taken while idle gives writes to indices 0, 1, ... in ascending order. There is exactly one write per cycle, and the first write is in the cycle right after the start edge.
- R3: An element whose mask bit (bit i of the captured mask) equals the captured polarity bit receives the first operand. In vector mode (`scalar_mode` = 0) that is `src_a_data` read at index i.
- R4: An element whose mask bit differs from the captured polarity bit receives `src_b_data` read at index i.
- R5: In scalar mode (`scalar_mode` = 1) every element that picks the first operand receives the captured 64-bit scalar.
- R6: A length of 0 produces no writes. `done` rises in the cycle right after the start edge.
- R7: A requested length above 64 is treated as 64, so elements 0..63 are written.
- R8: `done` is a one-cycle pulse in the cycle after the last write. `busy` is high in exactly the cycles that carry a write.
- R9: A start that arrives while busy is ignored. New length, mask, polarity or mode values presented with it do not change the running operation, and no extra operation follows.
- R10: No element at or beyond the captured length is ever written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| vlen | input | 7 | Requested element count, 0..127, capped at 64 |
| mask | input | 64 | Per-element select mask, bit i belongs to element i |
| polarity | input | 1 | Mask value that selects the first operand |
| scalar_mode | input | 1 | 1: first operand is the scalar; 0: vector A |
| scalar | input | 64 | Broadcast first operand |
| src_a_idx | output | 6 | Read index for vector A |
| src_a_data | input | 64 | Vector A element at `src_a_idx` |
| src_b_idx | output | 6 | Read index for vector B |
| src_b_data | input | 64 | Vector B element at `src_b_idx` |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | 6 | Destination element index |
| wr_data | output | 64 | Destination element value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default parameters: 64 elements, 64-bit data, and the scalar variant enabled. This covers both operand modes, the full mask width, and the length cap, because the 7-bit length port can ask for more than 64 elements. Those values let the tests run a zero-length operation, a full 64-element run, and a request of 100 that must stop at 64. A run with a start injected mid-operation, carrying flipped mask, polarity and length, shows that the captured operands stay in force.

// File: rtl/vmerge_pkg.sv
package vmerge_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   typedef struct packed {
      logic polarity;
      logic scalar_mode;
   } merge_ctl_t;

endpackage

// File: rtl/vmerge_seq.sv
module vmerge_seq
   import vmerge_pkg::*;
#(
   parameter int MAX_VL = 64,
   parameter int IDX_W  = $clog2(MAX_VL),
   parameter int LEN_W  = $clog2(MAX_VL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] vlen,
   output logic             accept,
   output logic             busy,
   output logic             done,
   output logic [IDX_W-1:0] idx,
   output logic [LEN_W-1:0] len_q
);

   localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_VL);

   seq_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             done_q;
   logic [LEN_W-1:0] len_clamped;
   logic             last_elem;

   assign accept      = start && (state_q == SEQ_IDLE);
   assign len_clamped = (vlen > CAP) ? CAP : vlen;
   assign last_elem   = (LEN_W'(idx_q) == (len_q - 1'b1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         len_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (accept) begin
                  len_q <= len_clamped;
                  idx_q <= '0;
                  if (len_clamped == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     state_q <= SEQ_RUN;
                  end
               end
            end
            SEQ_RUN: begin
               if (last_elem) begin
                  state_q <= SEQ_IDLE;
                  done_q  <= 1'b1;
                  idx_q   <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy = (state_q == SEQ_RUN);
   assign done = done_q;
   assign idx  = idx_q;

endmodule

// File: rtl/vmerge_capture.sv
module vmerge_capture
   import vmerge_pkg::*;
#(
   parameter int MAX_VL = 64,
   parameter int DW     = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [MAX_VL-1:0] mask,
   input  merge_ctl_t        ctl,
   input  logic [DW-1:0]     scalar,
   output logic [MAX_VL-1:0] mask_q,
   output merge_ctl_t        ctl_q,
   output logic [DW-1:0]     scalar_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q   <= '0;
         ctl_q    <= '0;
         scalar_q <= '0;
      end else if (accept) begin
         mask_q   <= mask;
         ctl_q    <= ctl;
         scalar_q <= scalar;
      end
   end

endmodule

// File: rtl/vmerge_pick.sv
module vmerge_pick
   import vmerge_pkg::*;
#(
   parameter int DW         = 64,
   parameter bit HAS_SCALAR = 1'b1
) (
   input  logic          mask_bit,
   input  merge_ctl_t    ctl,
   input  logic [DW-1:0] scalar_q,
   input  logic [DW-1:0] a_elem,
   input  logic [DW-1:0] b_elem,
   output logic [DW-1:0] result
);

   logic [DW-1:0] first_op;
   logic          take_first;

   generate
      if (HAS_SCALAR) begin : g_scalar
         assign first_op = ctl.scalar_mode ? scalar_q : a_elem;
      end else begin : g_vec_only
         logic unused_scalar;
         assign unused_scalar = ctl.scalar_mode ^ (^scalar_q);
         assign first_op = a_elem;
      end
   endgenerate

   assign take_first = (mask_bit == ctl.polarity);
   assign result     = take_first ? first_op : b_elem;

endmodule

// File: rtl/vmerge_unit.sv
module vmerge_unit
   import vmerge_pkg::*;
#(
   parameter int MAX_VL     = 64,
   parameter int DW         = 64,
   parameter bit HAS_SCALAR = 1'b1,
   parameter int IDX_W      = $clog2(MAX_VL),
   parameter int LEN_W      = $clog2(MAX_VL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  vlen,
   input  logic [MAX_VL-1:0] mask,
   input  logic              polarity,
   input  logic              scalar_mode,
   input  logic [DW-1:0]     scalar,
   output logic [IDX_W-1:0]  src_a_idx,
   input  logic [DW-1:0]     src_a_data,
   output logic [IDX_W-1:0]  src_b_idx,
   input  logic [DW-1:0]     src_b_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DW-1:0]     wr_data,
   output logic              busy,
   output logic              done
);

   generate
      if (MAX_VL < 2) begin : g_bad_len
         $error("vmerge_unit: MAX_VL must be at least 2");
      end
      if ((1 << IDX_W) != MAX_VL) begin : g_bad_pow2
         $error("vmerge_unit: MAX_VL must be a power of two");
      end
      if (DW < 1) begin : g_bad_dw
         $error("vmerge_unit: DW must be positive");
      end
   endgenerate

   logic              accept;
   logic              run;
   logic [IDX_W-1:0]  cur_idx;
   logic [LEN_W-1:0]  cur_len;
   logic [MAX_VL-1:0] cur_mask;
   merge_ctl_t        cur_ctl;
   logic [DW-1:0]     cur_scalar;
   merge_ctl_t        ctl_in;

   assign ctl_in.polarity    = polarity;
   assign ctl_in.scalar_mode = scalar_mode;

   vmerge_seq #(
      .MAX_VL (MAX_VL),
      .IDX_W  (IDX_W),
      .LEN_W  (LEN_W)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .vlen   (vlen),
      .accept (accept),
      .busy   (run),
      .done   (done),
      .idx    (cur_idx),
      .len_q  (cur_len)
   );

   vmerge_capture #(
      .MAX_VL (MAX_VL),
      .DW     (DW)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .mask     (mask),
      .ctl      (ctl_in),
      .scalar   (scalar),
      .mask_q   (cur_mask),
      .ctl_q    (cur_ctl),
      .scalar_q (cur_scalar)
   );

   vmerge_pick #(
      .DW         (DW),
      .HAS_SCALAR (HAS_SCALAR)
   ) u_pick (
      .mask_bit (cur_mask[cur_idx]),
      .ctl      (cur_ctl),
      .scalar_q (cur_scalar),
      .a_elem   (src_a_data),
      .b_elem   (src_b_data),
      .result   (wr_data)
   );

   assign src_a_idx = cur_idx;
   assign src_b_idx = cur_idx;
   assign wr_en     = run;
   assign wr_idx    = cur_idx;
   assign busy      = run;

endmodule

// File: rtl/vmerge_unit_chk.sv
module vmerge_unit_chk #(
   parameter int MAX_VL = 64,
   parameter int DW     = 64,
   parameter int IDX_W  = $clog2(MAX_VL),
   parameter int LEN_W  = $clog2(MAX_VL + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [DW-1:0]     wr_data,
   input logic [DW-1:0]     src_b_data,
   input logic [LEN_W-1:0]  cur_len,
   input logic [MAX_VL-1:0] cur_mask,
   input logic              cur_pol
);

   p_first_index_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !$past(wr_en)) |-> (wr_idx == '0));

   p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> (wr_idx == $past(wr_idx) + 1'b1));

   p_second_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (cur_mask[wr_idx] != cur_pol)) |-> (wr_data == src_b_data));

   p_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cur_len <= LEN_W'(MAX_VL));

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !wr_en));

   p_done_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_hold_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(cur_mask) && $stable(cur_pol) && $stable(cur_len)));

   p_below_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (LEN_W'(wr_idx) < cur_len));

endmodule

bind vmerge_unit vmerge_unit_chk #(
   .MAX_VL (MAX_VL),
   .DW     (DW),
   .IDX_W  (IDX_W),
   .LEN_W  (LEN_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .wr_en      (wr_en),
   .wr_idx     (wr_idx),
   .wr_data    (wr_data),
   .src_b_data (src_b_data),
   .cur_len    (cur_len),
   .cur_mask   (cur_mask),
   .cur_pol    (cur_ctl.polarity)
);

// File: tb/vmerge_unit_test.sv
module vmerge_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 64;
   localparam int DW = 64;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [6:0]     vlen = '0;
   logic [NV-1:0]  mask = '0;
   logic           polarity = 1'b0;
   logic           scalar_mode = 1'b0;
   logic [DW-1:0]  scalar = '0;
   logic [5:0]     src_a_idx, src_b_idx, wr_idx;
   logic [DW-1:0]  src_a_data, src_b_data, wr_data;
   logic           wr_en, busy, done;

   logic [DW-1:0]  va [NV];
   logic [DW-1:0]  vb [NV];

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign src_a_data = va[src_a_idx];
   assign src_b_data = vb[src_b_idx];

   vmerge_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .mask(mask),
      .polarity(polarity), .scalar_mode(scalar_mode), .scalar(scalar),
      .src_a_idx(src_a_idx), .src_a_data(src_a_data),
      .src_b_idx(src_b_idx), .src_b_data(src_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Runs one operation. inj_at > 0 pulses start again with altered inputs at
   // that negedge count, which must be ignored (R9).
   task automatic run_op(input int vl, input logic [NV-1:0] m, input bit pol,
                         input bit smode, input logic [DW-1:0] sc,
                         input int inj_at, input string tag);
      int exp_n;
      int n;
      int wcount;
      bit done_seen;
      int done_at;
      exp_n = (vl > NV) ? NV : vl;
      vlen = 7'(vl); mask = m; polarity = pol; scalar_mode = smode; scalar = sc;
      start = 1'b1;
      n = 0; wcount = 0; done_seen = 0; done_at = 0;
      while (!done_seen && n < 200) begin
         @(negedge clk);
         n++;
         if (wr_en) begin
            logic [DW-1:0] e;
            if (m[wcount] == pol) e = smode ? sc : va[wcount];
            else                  e = vb[wcount];
            check(wr_idx == 6'(wcount), {tag, " R2/R10 index"}, 64'(wr_idx), 64'(wcount));
            check(wr_data == e,
                  {tag, (m[wcount] == pol) ? (smode ? " R5 scalar" : " R3 first")
                                           : " R4 second"}, wr_data, e);
            check(n == wcount + 1, {tag, " R2 one per cycle"}, 64'(n), 64'(wcount + 1));
            check(busy, {tag, " R8 busy with write"}, 64'(busy), 64'd1);
            wcount++;
         end
         if (done) begin
            done_seen = 1;
            done_at = n;
         end
         if (inj_at > 0 && n == inj_at) begin
            start = 1'b1; mask = ~m; polarity = ~pol; scalar_mode = ~smode; vlen = 7'd3;
         end else begin
            start = 1'b0;
         end
      end
      check(wcount == exp_n, {tag, " R10/R7 write count"}, 64'(wcount), 64'(exp_n));
      check(done_at == exp_n + 1, {tag, " R8/R6 done cycle"}, 64'(done_at), 64'(exp_n + 1));
      @(negedge clk);
      check(!done && !busy && !wr_en, {tag, " R8/R9 single pulse, no rerun"},
            {61'd0, done, busy, wr_en}, 64'd0);
      @(negedge clk);
      check(!busy && !wr_en, {tag, " R9 idle after run"}, {62'd0, busy, wr_en}, 64'd0);
   endtask

   task automatic t_reset();
      check(!busy && !done && !wr_en, "R1 reset state", {61'd0, busy, done, wr_en}, 64'd0);
   endtask

   task automatic t_vector_mix();
      run_op(8, 64'hA5, 1'b1, 1'b0, '0, 0, "vec pol1");   // R3 R4
      run_op(8, 64'hA5, 1'b0, 1'b0, '0, 0, "vec pol0");   // R3 R4 polarity flip
   endtask

   task automatic t_scalar();
      run_op(5, 64'h0B, 1'b1, 1'b1, 64'hDEAD_BEEF_0123_4567, 0, "scalar");  // R5
   endtask

   task automatic t_zero_len();
      run_op(0, '1, 1'b1, 1'b0, '0, 0, "zero len");  // R6
   endtask

   task automatic t_full();
      run_op(64, 64'hF0F0_1234_8001_7E7E, 1'b0, 1'b0, '0, 0, "full 64");  // R2 R10
   endtask

   task automatic t_clamp();
      run_op(100, 64'h8000_0000_0000_0001, 1'b1, 1'b1, 64'h1111_2222_3333_4444, 0,
             "len 100");  // R7
   endtask

   task automatic t_busy_start();
      run_op(10, 64'h2CA, 1'b1, 1'b0, 64'h77, 3, "busy start");  // R9
   endtask

   initial begin
      for (int i = 0; i < NV; i++) begin
         va[i] = 64'hAAAA_0000_0000_0000 | 64'(i * 3 + 1);
         vb[i] = 64'h5555_0000_0000_0000 | 64'(i * 7 + 2);
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_vector_mix();
      t_scalar();
      t_zero_len();
      t_full();
      t_clamp();
      t_busy_start();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule